// File: doc/BRIEF.md
# 1-Wire Search ROM Accelerator

This block walks the ROM search tree of a 1-Wire bus in hardware, so the host does not have to run three bus slots per ID bit in software. The host first resets the bus and sends the search command byte with the accelerator off, in plain byte mode. It then raises the search enable and writes sixteen bytes. Each written byte gives the branch preference for four search steps. Each returned byte packs the four chosen ID bits and four discrepancy flags. Response byte i carries ID bits 4i to 4i+3, so the sixteen responses together hold the 64-bit ID of one device, lowest nibble first.

Each search step runs three slots on the bit-slot engine. Two are read slots: the first samples the ID bit and the second samples its complement. The third is a write slot that drives the chosen direction, and devices whose bit differs from it drop out of the search. With the enable low, a written byte becomes eight slots, least significant bit first, and the sampled line levels come back as the response byte. The bit-slot engine sits behind a request/acknowledge port with one bit in each direction. Bus timing lives in that engine, outside this block.

Top module: `ow_search_accel`

## Requirements
- R1: While reset is held and right after it, `host_ready` is 1, `rsp_valid` is 0 and `slot_req` is 0.
- R2: In search mode, step k (k = 0..3) of a byte puts its chosen direction in response bit 2k+1 and its discrepancy flag in response bit 2k.
- R3: When the ID read and the complement read of a step differ, the direction is the ID read value and the discrepancy flag is 0.
- R4: When both reads of a step return 0, the discrepancy flag is 1 and the direction is bit 2k+1 of the written byte, so a written byte of 0x00 takes the 0 branch at every discrepancy.
- R5: When both reads of a step return 1 (no device answering), the step records direction 1 with discrepancy flag 1.
- R6: Each search step issues exactly three slots in this order: an ID read slot and a complement read slot (both with `slot_bit` = 1), then a write slot whose `slot_bit` is the chosen direction.
- R7: `rsp_valid` is a one-cycle pulse, given once per accepted byte and only after the acknowledge of its last slot. `host_ready` is 0 from acceptance until that pulse.
- R8: With the search enable low at acceptance, a byte runs eight slots. Slot i drives data bit i (bit 0 first), and response bit i is the value sampled in slot i.
- R9: Sixteen search bytes give the full 64-bit ID, with response byte i supplying ID bits 4i..4i+3 from its odd-position bits.
- R10: The mode is captured when a byte is accepted, so a change of `search_en` during a transfer does not affect that transfer. `slot_req` stays high until `slot_ack` and is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| search_en | input | 1 | Search accelerator enable, captured at byte acceptance |
| host_valid | input | 1 | Host offers a byte |
| host_data | input | 8 | Byte from host (data bits, or branch preferences in odd bits) |
| host_ready | output | 1 | Block idle, can accept a byte |
| rsp_valid | output | 1 | Response byte available (one-cycle pulse) |
| rsp_data | output | 8 | Response byte |
| slot_req | output | 1 | Request one bus slot |
| slot_bit | output | 1 | Bit to drive in the slot (1 means a read slot) |
| slot_ack | input | 1 | Slot finished (one-cycle pulse) |
| slot_rbit | input | 1 | Line level sampled in the finished slot |

## Verification
The hardest case to reach is a step where both reads return 0 and the host's preference decides the branch. It needs at least two devices whose IDs differ at a known bit, and the wired-AND of the bus has to hold across both reads. The bench models a small pool of devices that answer read slots with the wired-AND of their bits and drop out on write slots. One pair of IDs differs only at bit 5, and that pair is searched once with preference 0x00 and once with 0xAA. An empty pool gives the all-ones case, and random pools with random preferences cover deeper trees.

// File: rtl/owsra_pkg.sv
package owsra_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SLOT = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } st_e;

    typedef enum logic [1:0] {
        PH_ID  = 2'd0,
        PH_CMP = 2'd1,
        PH_WR  = 2'd2
    } ph_e;
endpackage

// File: rtl/owsra_decide.sv
module owsra_decide (
    input  logic id_bit,
    input  logic cmp_bit,
    input  logic pref_bit,
    output logic dir_bit,
    output logic disc_bit
);
    always_comb begin
        if (id_bit != cmp_bit) begin
            dir_bit  = id_bit;       // all remaining devices agree
            disc_bit = 1'b0;
        end else if (!id_bit) begin
            dir_bit  = pref_bit;     // devices disagree: host preference
            disc_bit = 1'b1;
        end else begin
            dir_bit  = 1'b1;         // nobody answered
            disc_bit = 1'b1;
        end
    end
endmodule

// File: rtl/owsra_pack.sv
module owsra_pack #(
    parameter int STEPS  = 4,
    parameter int STEP_W = 2
) (
    input  logic [2*STEPS-1:0] res_in,
    input  logic [STEP_W-1:0]  step,
    input  logic               dir_bit,
    input  logic               disc_bit,
    output logic [2*STEPS-1:0] res_out
);
    for (genvar k = 0; k < STEPS; k++) begin : g_step
        assign res_out[2*k+1] = (step == STEP_W'(k)) ? dir_bit  : res_in[2*k+1];
        assign res_out[2*k]   = (step == STEP_W'(k)) ? disc_bit : res_in[2*k];
    end
endmodule

// File: rtl/ow_search_accel.sv
module ow_search_accel #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              search_en,
    input  logic              host_valid,
    input  logic [BYTE_W-1:0] host_data,
    output logic              host_ready,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              slot_req,
    output logic              slot_bit,
    input  logic              slot_ack,
    input  logic              slot_rbit
);
    import owsra_pkg::*;

    localparam int STEPS  = BYTE_W / 2;
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam int STEP_W = $clog2(STEPS);

    typedef struct packed {
        st_e              st;
        ph_e              ph;
        logic             search;
        logic [BYTE_W-1:0] din;
        logic [BYTE_W-1:0] res;
        logic [IDX_W-1:0] idx;
        logic             id_bit;
        logic             cmp_bit;
    } regs_t;

    regs_t r_q, r_d;

    logic [STEPS-1:0]  pref_bits;
    logic              dir_bit, disc_bit, pref_bit;
    logic [BYTE_W-1:0] packed_res;

    for (genvar k = 0; k < STEPS; k++) begin : g_pref
        assign pref_bits[k] = r_q.din[2*k+1];
    end
    assign pref_bit = pref_bits[r_q.idx[STEP_W-1:0]];

    owsra_decide i_decide (
        .id_bit  (r_q.id_bit),
        .cmp_bit (r_q.cmp_bit),
        .pref_bit(pref_bit),
        .dir_bit (dir_bit),
        .disc_bit(disc_bit)
    );

    owsra_pack #(.STEPS(STEPS), .STEP_W(STEP_W)) i_pack (
        .res_in  (r_q.res),
        .step    (r_q.idx[STEP_W-1:0]),
        .dir_bit (dir_bit),
        .disc_bit(disc_bit),
        .res_out (packed_res)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (host_valid) begin
                    r_d.st      = ST_SLOT;
                    r_d.ph      = PH_ID;
                    r_d.search  = search_en;
                    r_d.din     = host_data;
                    r_d.res     = '0;
                    r_d.idx     = '0;
                    r_d.id_bit  = 1'b0;
                    r_d.cmp_bit = 1'b0;
                end
            end
            ST_SLOT: begin
                if (slot_ack) begin
                    r_d.st = ST_GAP;
                    if (!r_q.search) begin
                        r_d.res[r_q.idx] = slot_rbit;
                        if (r_q.idx == IDX_W'(BYTE_W - 1)) r_d.st = ST_DONE;
                        else r_d.idx = r_q.idx + 1'b1;
                    end else begin
                        unique case (r_q.ph)
                            PH_ID: begin
                                r_d.id_bit = slot_rbit;
                                r_d.ph     = PH_CMP;
                            end
                            PH_CMP: begin
                                r_d.cmp_bit = slot_rbit;
                                r_d.ph      = PH_WR;
                            end
                            default: begin
                                r_d.res = packed_res;
                                r_d.ph  = PH_ID;
                                if (r_q.idx == IDX_W'(STEPS - 1)) r_d.st = ST_DONE;
                                else r_d.idx = r_q.idx + 1'b1;
                            end
                        endcase
                    end
                end
            end
            ST_GAP:  r_d.st = ST_SLOT;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.ph      <= PH_ID;
            r_q.search  <= 1'b0;
            r_q.din     <= '0;
            r_q.res     <= '0;
            r_q.idx     <= '0;
            r_q.id_bit  <= 1'b0;
            r_q.cmp_bit <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_ready = (r_q.st == ST_IDLE);
    assign rsp_valid  = (r_q.st == ST_DONE);
    assign rsp_data   = r_q.res;
    assign slot_req   = (r_q.st == ST_SLOT);
    assign slot_bit   = r_q.search ? ((r_q.ph == PH_WR) ? dir_bit : 1'b1)
                                   : r_q.din[r_q.idx];
endmodule

// File: rtl/ow_search_accel_chk.sv
module ow_search_accel_chk #(
    parameter int BYTE_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic search_en,
    input logic host_valid,
    input logic host_ready,
    input logic rsp_valid,
    input logic slot_req,
    input logic slot_bit,
    input logic slot_ack
);
    localparam int SRCH_SLOTS = 3 * (BYTE_W / 2);
    localparam int CNT_W      = $clog2(SRCH_SLOTS + BYTE_W + 1);

    logic [CNT_W-1:0] cnt;
    logic             mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            mode <= 1'b0;
        end else if (host_valid && host_ready) begin
            cnt  <= '0;
            mode <= search_en;
        end else if (slot_req && slot_ack) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_idle_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> !slot_req);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !slot_ack) |=> slot_req);
    assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && slot_ack) |=> !slot_req);
    assert_slot_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (cnt == (mode ? CNT_W'(SRCH_SLOTS) : CNT_W'(BYTE_W))));
    assert_read_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && slot_req && (cnt % 3 != 2)) |-> slot_bit);
endmodule

bind ow_search_accel ow_search_accel_chk #(.BYTE_W(BYTE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .search_en(search_en), .host_valid(host_valid),
    .host_ready(host_ready), .rsp_valid(rsp_valid), .slot_req(slot_req),
    .slot_bit(slot_bit), .slot_ack(slot_ack)
);

// File: tb/test_ow_search_accel.sv
module test_ow_search_accel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       search_en = 1'b0, host_valid = 1'b0;
    logic [7:0] host_data = '0;
    logic       host_ready, rsp_valid, slot_req, slot_bit;
    logic [7:0] rsp_data;
    logic       slot_ack = 1'b0, slot_rbit = 1'b0;

    int n_tests = 0, n_fail = 0;

    ow_search_accel i_ow_search_accel (
        .clk(clk), .rst_n(rst_n), .search_en(search_en), .host_valid(host_valid),
        .host_data(host_data), .host_ready(host_ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .slot_req(slot_req), .slot_bit(slot_bit),
        .slot_ack(slot_ack), .slot_rbit(slot_rbit)
    );

    always #5 clk = ~clk;

    // device pool model
    logic [63:0] rom [4];
    int          ndev;
    logic [3:0]  m_act, e_act;
    int          m_pos, m_slot, e_pos, n_idx, wait_cnt;
    logic [7:0]  nmask;
    bit          mode_s;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic wand_bit(input logic [3:0] act, input int pos, input bit inv);
        logic v = 1'b1;
        for (int d = 0; d < 4; d++)
            if (d < ndev && act[d]) v = v & (inv ? ~rom[d][pos] : rom[d][pos]);
        return v;
    endfunction

    function automatic logic [3:0] prune(input logic [3:0] act, input int pos, input logic b);
        logic [3:0] a = act;
        for (int d = 0; d < 4; d++)
            if (d < ndev && rom[d][pos] != b) a[d] = 1'b0;
        return a;
    endfunction

    // bit-slot engine with attached devices
    initial begin
        wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (slot_ack) slot_ack = 1'b0;
            else if (slot_req) begin
                if (wait_cnt > 0) wait_cnt--;
                else begin
                    if (mode_s) begin
                        case (m_slot % 3)
                            0: begin
                                chk(slot_bit == 1'b1, "R6 id read slot", slot_bit, 1);
                                slot_rbit = wand_bit(m_act, m_pos, 0);
                            end
                            1: begin
                                chk(slot_bit == 1'b1, "R6 cmp read slot", slot_bit, 1);
                                slot_rbit = wand_bit(m_act, m_pos, 1);
                            end
                            default: begin
                                m_act = prune(m_act, m_pos, slot_bit);
                                m_pos++;
                                slot_rbit = slot_bit;
                            end
                        endcase
                        m_slot++;
                    end else begin
                        slot_rbit = slot_bit & nmask[n_idx % 8];
                        n_idx++;
                    end
                    slot_ack = 1'b1;
                    wait_cnt = $urandom_range(0, 2);
                end
            end
        end
    end

    task automatic exp_byte(input logic [7:0] pref, output logic [7:0] r);
        for (int k = 0; k < 4; k++) begin
            logic id, cp, dir, disc;
            id = wand_bit(e_act, e_pos, 0);
            cp = wand_bit(e_act, e_pos, 1);
            if (id != cp) begin dir = id; disc = 0; end
            else if (!id) begin dir = pref[2*k+1]; disc = 1; end
            else begin dir = 1; disc = 1; end
            r[2*k+1] = dir;
            r[2*k]   = disc;
            e_act = prune(e_act, e_pos, dir);
            e_pos++;
        end
    endtask

    task automatic xfer(input bit mode, input logic [7:0] d, output logic [7:0] r);
        int guard = 0;
        mode_s = mode;
        while (!host_ready) @(negedge clk);
        search_en = mode; host_valid = 1'b1; host_data = d;
        @(negedge clk);
        host_valid = 1'b0;
        search_en = ~mode;   // R10: change after acceptance must not matter
        chk(!host_ready, "R7 busy after accept", host_ready, 0);
        while (!rsp_valid && guard < 400) begin @(negedge clk); guard++; end
        chk(rsp_valid, "R7 response arrives", rsp_valid, 1);
        r = rsp_data;
        @(negedge clk);
        chk(!rsp_valid, "R7 one-cycle pulse", rsp_valid, 0);
    endtask

    task automatic start_search();
        m_act = 4'hF; e_act = 4'hF; m_pos = 0; e_pos = 0; m_slot = 0;
    endtask

    task automatic run_search(input logic [7:0] pref, input bit rnd, output logic [63:0] id,
                              input string tag);
        logic [7:0] r, e, p;
        start_search();
        id = '0;
        for (int i = 0; i < 16; i++) begin
            p = rnd ? 8'($urandom) : pref;
            exp_byte(p, e);
            xfer(1'b1, p, r);
            chk(r == e, tag, r, e);
            for (int k = 0; k < 4; k++) id[4*i+k] = r[2*k+1];
        end
    endtask

    initial begin
        logic [7:0]  r;
        logic [63:0] id;
        void'($urandom(32'h5EA4C4));
        ndev = 0; nmask = 8'hFF; n_idx = 0; mode_s = 0;
        start_search();
        repeat (4) @(negedge clk);
        chk(host_ready && !rsp_valid && !slot_req, "R1 reset state",
            {host_ready, rsp_valid, slot_req}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready && !rsp_valid && !slot_req, "R1 after reset",
            {host_ready, rsp_valid, slot_req}, 3'b100);

        // R8: normal byte mode
        for (int t = 0; t < 12; t++) begin
            logic [7:0] d;
            d = 8'($urandom); nmask = (t == 0) ? 8'h01 : 8'($urandom); n_idx = 0;
            xfer(1'b0, d, r);
            chk(r == (d & nmask), "R8 normal byte", r, d & nmask);
        end

        // R3/R9: single device, no discrepancies
        ndev = 1;
        for (int t = 0; t < 3; t++) begin
            rom[0] = {$urandom, $urandom};
            run_search(8'h00, 1, id, "R3 R2 single device byte");
            chk(id == rom[0], "R9 recovered id", id, rom[0]);
        end

        // R4: two devices differing only at bit 5
        ndev = 2;
        rom[0] = 64'h3C5A_9611_0F0F_1234 & ~64'h20;
        rom[1] = rom[0] | 64'h20;
        run_search(8'h00, 0, id, "R4 R2 pref zero byte");
        chk(id == rom[0], "R4 zero branch id", id, rom[0]);
        run_search(8'hAA, 0, id, "R4 R2 pref ones byte");
        chk(id == rom[1], "R4 one branch id", id, rom[1]);

        // R5: empty bus
        ndev = 0;
        start_search();
        for (int i = 0; i < 3; i++) begin
            xfer(1'b1, 8'($urandom), r);
            chk(r == 8'hFF, "R5 no device", r, 8'hFF);
        end

        // random pools
        ndev = 3;
        for (int t = 0; t < 4; t++) begin
            for (int d = 0; d < 4; d++) rom[d] = {$urandom, $urandom};
            rom[1][7:0] = rom[0][7:0];
            run_search(8'h00, 1, id, "R2 R4 random pool byte");
            chk(id == rom[0] || id == rom[1] || id == rom[2], "R9 id in pool", id, rom[0]);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule